// File: doc/BRIEF.md
# Interrupt Nesting Level Controller

This block keeps count of how deeply a processor is nested inside interrupt and exception handlers and saves the interrupted state at each step inward. The nesting level runs from 0, where no handler is active, up to 2 or 3, depending on a configuration bit. The first two steps inward each push the current program counter, status word, faulting address, cause code and two argument words onto a two-deep shadow stack. The third step is only possible in 3-level mode. It saves just the program counter, into a register of its own.

A return request steps the level back out. It restores the shadow stack, except when leaving the third level, because that level never touched the stack. Two combinational results are given alongside the level. The first is the status word the core should load on entry. The second is the handler address, taken from a vector base and an entry index scaled by a configurable spacing. There are two vector-table sizes: an internal one with 16 entries on a 4-bit index, and an external one with 73 entries on a 7-bit index.

Top module: `irq_nest_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it, the level is 0 and every saved register (both stack places of all six fields and the deep PC register) reads 0.
- R2: An entry request at level 0 or 1 raises the level by one. For each of the six fields (PC, PSW, address, cause, argument 0, argument 1), the saved copy moves to the old copy and the current input is captured as the saved copy. These results are visible after the clock edge that samples the request.
- R3: An entry request at level 2 with 3-level mode selected (cfg_three_lvl=1) sets the level to 3 and copies cur_pc into deep_pc. All twelve shadow-stack registers stay unchanged.
- R4: An entry request is ignored when the level has reached its ceiling, which is 2 with cfg_three_lvl=0 and 3 with cfg_three_lvl=1. The level and every saved register keep their values.
- R5: A return request without an entry request, at level 1 or 2, lowers the level by one. For each field the old copy moves back into the saved copy, and the old copy keeps its value.
- R6: A return request without an entry request, at level 3, sets the level to 2. The shadow stack and deep_pc keep their values.
- R7: A return request at level 0 is ignored. When entry and return are requested in the same cycle, the entry is handled and the return is dropped.
- R8: new_psw equals cur_psw with bit 0 (interrupt enable), bit 1 (user mode), bit 2 (instruction translation) and bit 3 (data translation) cleared, and bit 4 (big-endian) set to the DEF_BIG_END parameter (default 0). All other bits are copied. The output is combinational.
- R9: With cfg_ext_vec=0, vec_addr = vec_base + (enter_idx[3:0] << vec_shift), computed modulo 2^32. Index bits 6..4 have no effect. The output is combinational.
- R10: With cfg_ext_vec=1, vec_addr = vec_base + (enter_idx[6:0] << vec_shift), computed modulo 2^32. The output is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_three_lvl | input | 1 | 1 allows a third nesting level, 0 caps the level at 2 |
| cfg_ext_vec | input | 1 | 1 selects the 73-entry table on a 7-bit index, 0 selects the 16-entry table on a 4-bit index |
| vec_base | input | 32 | Base address of the vector table |
| vec_shift | input | 5 | log2 of the spacing between vector entries |
| cur_pc | input | 32 | PC of the interrupted instruction |
| cur_psw | input | 32 | Current status word |
| cur_va | input | 32 | Faulting virtual address |
| cur_itype | input | 32 | Cause code of the interruption |
| cur_arg0 | input | 32 | First parameter word |
| cur_arg1 | input | 32 | Second parameter word |
| enter_req | input | 1 | Request to step one level inward |
| enter_idx | input | 7 | Vector entry index of the cause |
| ret_req | input | 1 | Request to step one level outward |
| lvl | output | 2 | Current nesting level |
| sav_pc | output | 32 | Saved PC, innermost stack place |
| old_pc | output | 32 | Saved PC, deeper stack place |
| sav_psw | output | 32 | Saved PSW, innermost |
| old_psw | output | 32 | Saved PSW, deeper |
| sav_va | output | 32 | Saved faulting address, innermost |
| old_va | output | 32 | Saved faulting address, deeper |
| sav_cause | output | 32 | Saved cause code, innermost |
| old_cause | output | 32 | Saved cause code, deeper |
| sav_arg0 | output | 32 | Saved argument 0, innermost |
| old_arg0 | output | 32 | Saved argument 0, deeper |
| sav_arg1 | output | 32 | Saved argument 1, innermost |
| old_arg1 | output | 32 | Saved argument 1, deeper |
| deep_pc | output | 32 | PC saved on the step to level 3 |
| new_psw | output | 32 | Status word to load on entry |
| vec_addr | output | 32 | Handler address for enter_idx |

## Verification
The level and all saved registers change on the clock edge that samples a request. The bench drives each request just after a falling edge and compares these registered results 1 ns after the following rising edge, which is exactly one edge later. new_psw and vec_addr are combinational, so they are compared 1 ns after the inputs change, within the same low phase and before any edge. Each compare is tagged with the requirement that matches the kind of step the bench model predicted: push, deep save, ignored entry, pop, leave-deep, or ignored return.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  // status-word bit positions the entry rule rewrites
  localparam int PSW_INTEN  = 0;
  localparam int PSW_USER   = 1;
  localparam int PSW_ITRANS = 2;
  localparam int PSW_DTRANS = 3;
  localparam int PSW_BIGEND = 4;

  // order of the six shadowed fields
  localparam int NFIELD  = 6;
  localparam int FLD_PC  = 0;
  localparam int FLD_PSW = 1;
  localparam int FLD_VA  = 2;
  localparam int FLD_CAU = 3;
  localparam int FLD_A0  = 4;
  localparam int FLD_A1  = 5;

  typedef enum logic [2:0] {
    STEP_IDLE   = 3'd0,
    STEP_PUSH   = 3'd1,   // 0->1 or 1->2
    STEP_DEEP   = 3'd2,   // 2->3
    STEP_POP    = 3'd3,   // 2->1 or 1->0
    STEP_UNDEEP = 3'd4    // 3->2
  } step_e;

endpackage

// File: rtl/irq_nest_level.sv
module irq_nest_level
  import irq_nest_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_three_lvl,
  input  logic       enter_req,
  input  logic       ret_req,
  output logic [1:0] lvl,
  output step_e      step
);

  logic [1:0] lvl_q;

  always_comb begin
    step = STEP_IDLE;
    if (enter_req) begin
      if (lvl_q < 2'd2)                         step = STEP_PUSH;
      else if (lvl_q == 2'd2 && cfg_three_lvl)  step = STEP_DEEP;
    end else if (ret_req) begin
      if (lvl_q == 2'd3)                        step = STEP_UNDEEP;
      else if (lvl_q != 2'd0)                   step = STEP_POP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 2'd0;
    end else begin
      case (step)
        STEP_PUSH, STEP_DEEP:  lvl_q <= lvl_q + 2'd1;
        STEP_POP, STEP_UNDEEP: lvl_q <= lvl_q - 2'd1;
        default:               lvl_q <= lvl_q;
      endcase
    end
  end

  assign lvl = lvl_q;

  assert_two_level_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_three_lvl && lvl_q <= 2'd2) |=> (lvl_q <= 2'd2));

  assert_push_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_req && lvl_q <= 2'd1) |=> (lvl_q == $past(lvl_q) + 2'd1));

  assert_idle_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !enter_req && lvl_q == 2'd0) |=> (lvl_q == 2'd0));

  assert_leave_deep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !enter_req && lvl_q == 2'd3) |=> (lvl_q == 2'd2));

endmodule

// File: rtl/irq_nest_shadow.sv
module irq_nest_shadow #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] d,
  output logic [W-1:0] cur_q,
  output logic [W-1:0] prv_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      prv_q <= '0;
    end else if (push) begin
      prv_q <= cur_q;
      cur_q <= d;
    end else if (pop) begin
      cur_q <= prv_q;
    end
  end

  assert_push_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (prv_q == $past(cur_q) && cur_q == $past(d)));

  assert_pop_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (cur_q == $past(prv_q) && $stable(prv_q)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> ($stable(cur_q) && $stable(prv_q)));

endmodule

// File: rtl/irq_nest_vector.sv
module irq_nest_vector #(
  parameter int XLEN     = 32,
  parameter int SHW      = 5,
  parameter int EXT_IDXW = 7,
  parameter int INT_IDXW = 4
) (
  input  logic                ext_mode,
  input  logic [XLEN-1:0]     base,
  input  logic [EXT_IDXW-1:0] idx,
  input  logic [SHW-1:0]      shift,
  output logic [XLEN-1:0]     addr
);

  function automatic logic [XLEN-1:0] entry_offset(
    input logic                ext,
    input logic [EXT_IDXW-1:0] i,
    input logic [SHW-1:0]      sh
  );
    logic [XLEN-1:0] sel;
    sel = '0;
    if (ext) sel[EXT_IDXW-1:0] = i;
    else     sel[INT_IDXW-1:0] = i[INT_IDXW-1:0];
    return sel << sh;
  endfunction

  assign addr = base + entry_offset(ext_mode, idx, shift);

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int   XLEN        = 32,
  parameter int   SHW         = 5,
  parameter int   EXT_IDXW    = 7,
  parameter int   INT_IDXW    = 4,
  parameter logic DEF_BIG_END = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_three_lvl,
  input  logic                cfg_ext_vec,
  input  logic [XLEN-1:0]     vec_base,
  input  logic [SHW-1:0]      vec_shift,
  input  logic [XLEN-1:0]     cur_pc,
  input  logic [XLEN-1:0]     cur_psw,
  input  logic [XLEN-1:0]     cur_va,
  input  logic [XLEN-1:0]     cur_itype,
  input  logic [XLEN-1:0]     cur_arg0,
  input  logic [XLEN-1:0]     cur_arg1,
  input  logic                enter_req,
  input  logic [EXT_IDXW-1:0] enter_idx,
  input  logic                ret_req,
  output logic [1:0]          lvl,
  output logic [XLEN-1:0]     sav_pc,
  output logic [XLEN-1:0]     old_pc,
  output logic [XLEN-1:0]     sav_psw,
  output logic [XLEN-1:0]     old_psw,
  output logic [XLEN-1:0]     sav_va,
  output logic [XLEN-1:0]     old_va,
  output logic [XLEN-1:0]     sav_cause,
  output logic [XLEN-1:0]     old_cause,
  output logic [XLEN-1:0]     sav_arg0,
  output logic [XLEN-1:0]     old_arg0,
  output logic [XLEN-1:0]     sav_arg1,
  output logic [XLEN-1:0]     old_arg1,
  output logic [XLEN-1:0]     deep_pc,
  output logic [XLEN-1:0]     new_psw,
  output logic [XLEN-1:0]     vec_addr
);

  function automatic logic [XLEN-1:0] entry_psw(input logic [XLEN-1:0] p);
    logic [XLEN-1:0] r;
    r = p;
    r[PSW_INTEN]  = 1'b0;
    r[PSW_USER]   = 1'b0;
    r[PSW_ITRANS] = 1'b0;
    r[PSW_DTRANS] = 1'b0;
    r[PSW_BIGEND] = DEF_BIG_END;
    return r;
  endfunction

  step_e step;
  logic  stk_push, stk_pop, deep_save;
  logic [XLEN-1:0] fld_in  [NFIELD];
  logic [XLEN-1:0] fld_cur [NFIELD];
  logic [XLEN-1:0] fld_prv [NFIELD];
  logic [XLEN-1:0] deep_q;

  irq_nest_level u_level (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_three_lvl(cfg_three_lvl),
    .enter_req    (enter_req),
    .ret_req      (ret_req),
    .lvl          (lvl),
    .step         (step)
  );

  assign stk_push  = (step == STEP_PUSH);
  assign stk_pop   = (step == STEP_POP);
  assign deep_save = (step == STEP_DEEP);

  assign fld_in[FLD_PC]  = cur_pc;
  assign fld_in[FLD_PSW] = cur_psw;
  assign fld_in[FLD_VA]  = cur_va;
  assign fld_in[FLD_CAU] = cur_itype;
  assign fld_in[FLD_A0]  = cur_arg0;
  assign fld_in[FLD_A1]  = cur_arg1;

  for (genvar g = 0; g < NFIELD; g++) begin : g_shadow
    irq_nest_shadow #(.W(XLEN)) u_shadow (
      .clk  (clk),
      .rst_n(rst_n),
      .push (stk_push),
      .pop  (stk_pop),
      .d    (fld_in[g]),
      .cur_q(fld_cur[g]),
      .prv_q(fld_prv[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         deep_q <= '0;
    else if (deep_save) deep_q <= cur_pc;
  end

  assign sav_pc    = fld_cur[FLD_PC];
  assign old_pc    = fld_prv[FLD_PC];
  assign sav_psw   = fld_cur[FLD_PSW];
  assign old_psw   = fld_prv[FLD_PSW];
  assign sav_va    = fld_cur[FLD_VA];
  assign old_va    = fld_prv[FLD_VA];
  assign sav_cause = fld_cur[FLD_CAU];
  assign old_cause = fld_prv[FLD_CAU];
  assign sav_arg0  = fld_cur[FLD_A0];
  assign old_arg0  = fld_prv[FLD_A0];
  assign sav_arg1  = fld_cur[FLD_A1];
  assign old_arg1  = fld_prv[FLD_A1];
  assign deep_pc   = deep_q;

  assign new_psw = entry_psw(cur_psw);

  irq_nest_vector #(
    .XLEN(XLEN), .SHW(SHW), .EXT_IDXW(EXT_IDXW), .INT_IDXW(INT_IDXW)
  ) u_vector (
    .ext_mode(cfg_ext_vec),
    .base    (vec_base),
    .idx     (enter_idx),
    .shift   (vec_shift),
    .addr    (vec_addr)
  );

  assert_deep_save_R3: assert property (@(posedge clk) disable iff (!rst_n)
    deep_save |=> (deep_q == $past(cur_pc) && lvl == 2'd3));

  assert_deep_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !deep_save |=> $stable(deep_q));

  assert_deep_no_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    deep_save |=> ($stable(sav_pc) && $stable(old_pc)));

  assert_one_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stk_push, stk_pop, deep_save}));

  always_comb begin
    assert_psw_clears_R8: assert (!rst_n || new_psw[PSW_INTEN:PSW_USER] == 2'b00);
  end

endmodule

// File: tb/test_irq_nest_ctrl.sv
module test_irq_nest_ctrl;

  localparam int XLEN = 32;
  localparam int SHW  = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cfg_three_lvl, cfg_ext_vec, enter_req, ret_req;
  logic [XLEN-1:0] vec_base, cur_pc, cur_psw, cur_va, cur_itype, cur_arg0, cur_arg1;
  logic [SHW-1:0]  vec_shift;
  logic [6:0]      enter_idx;
  logic [1:0]      lvl;
  logic [XLEN-1:0] sav_pc, old_pc, sav_psw, old_psw, sav_va, old_va;
  logic [XLEN-1:0] sav_cause, old_cause, sav_arg0, old_arg0, sav_arg1, old_arg1;
  logic [XLEN-1:0] deep_pc, new_psw, vec_addr;

  irq_nest_ctrl i_irq_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_three_lvl(cfg_three_lvl), .cfg_ext_vec(cfg_ext_vec),
    .vec_base(vec_base), .vec_shift(vec_shift), .cur_pc(cur_pc), .cur_psw(cur_psw),
    .cur_va(cur_va), .cur_itype(cur_itype), .cur_arg0(cur_arg0), .cur_arg1(cur_arg1),
    .enter_req(enter_req), .enter_idx(enter_idx), .ret_req(ret_req), .lvl(lvl),
    .sav_pc(sav_pc), .old_pc(old_pc), .sav_psw(sav_psw), .old_psw(old_psw),
    .sav_va(sav_va), .old_va(old_va), .sav_cause(sav_cause), .old_cause(old_cause),
    .sav_arg0(sav_arg0), .old_arg0(old_arg0), .sav_arg1(sav_arg1), .old_arg1(old_arg1),
    .deep_pc(deep_pc), .new_psw(new_psw), .vec_addr(vec_addr)
  );

  int  n_vec = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  // bench model of the state
  int unsigned m_lvl;
  logic [XLEN-1:0] m_top [6];
  logic [XLEN-1:0] m_low [6];
  logic [XLEN-1:0] m_deep;

  task automatic cmp(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] want_psw(logic [XLEN-1:0] p);
    return (p & ~32'h0000_001F);   // DEF_BIG_END = 0 at default
  endfunction

  function automatic logic [XLEN-1:0] want_vec(logic ext, logic [XLEN-1:0] b,
                                               logic [6:0] i, logic [SHW-1:0] s);
    logic [XLEN-1:0] k;
    k = ext ? XLEN'(i) : XLEN'(i & 7'h0F);
    return b + (k << s);
  endfunction

  task automatic compare_state(string tag);
    cmp(tag, "lvl", XLEN'(lvl), XLEN'(m_lvl));
    cmp(tag, "sav_pc", sav_pc, m_top[0]);    cmp(tag, "old_pc", old_pc, m_low[0]);
    cmp(tag, "sav_psw", sav_psw, m_top[1]);  cmp(tag, "old_psw", old_psw, m_low[1]);
    cmp(tag, "sav_va", sav_va, m_top[2]);    cmp(tag, "old_va", old_va, m_low[2]);
    cmp(tag, "sav_cause", sav_cause, m_top[3]); cmp(tag, "old_cause", old_cause, m_low[3]);
    cmp(tag, "sav_arg0", sav_arg0, m_top[4]);   cmp(tag, "old_arg0", old_arg0, m_low[4]);
    cmp(tag, "sav_arg1", sav_arg1, m_top[5]);   cmp(tag, "old_arg1", old_arg1, m_low[5]);
    cmp(tag, "deep_pc", deep_pc, m_deep);
  endtask

  task automatic model_reset();
    m_lvl = 0;
    m_deep = '0;
    for (int f = 0; f < 6; f++) begin
      m_top[f] = '0;
      m_low[f] = '0;
    end
  endtask

  task automatic randomize_data();
    cur_pc    = $urandom;  cur_psw   = $urandom;  cur_va   = $urandom;
    cur_itype = $urandom;  cur_arg0  = $urandom;  cur_arg1 = $urandom;
    vec_base  = $urandom;  vec_shift = SHW'($urandom % 8);
    enter_idx = 7'($urandom);
    cfg_ext_vec = 1'($urandom);
  endtask

  // one request cycle; called just after a falling edge
  task automatic apply(bit en, bit rt);
    logic [XLEN-1:0] ins [6];
    string tag;
    int unsigned cap;
    randomize_data();
    enter_req = en;
    ret_req   = rt;
    #1;
    cmp("R8", "new_psw", new_psw, want_psw(cur_psw));
    cmp(cfg_ext_vec ? "R10" : "R9", "vec_addr", vec_addr,
        want_vec(cfg_ext_vec, vec_base, enter_idx, vec_shift));
    ins[0] = cur_pc;    ins[1] = cur_psw;  ins[2] = cur_va;
    ins[3] = cur_itype; ins[4] = cur_arg0; ins[5] = cur_arg1;
    cap = cfg_three_lvl ? 3 : 2;
    if (en) begin
      if (m_lvl >= cap) begin
        tag = "R4";
      end else if (m_lvl == 2) begin
        tag = "R3";
        m_deep = cur_pc;
        m_lvl = 3;
      end else begin
        tag = "R2";
        for (int f = 0; f < 6; f++) begin
          m_low[f] = m_top[f];
          m_top[f] = ins[f];
        end
        m_lvl++;
      end
    end else if (rt) begin
      if (m_lvl == 0) begin
        tag = "R7";
      end else if (m_lvl == 3) begin
        tag = "R6";
        m_lvl = 2;
      end else begin
        tag = "R5";
        for (int f = 0; f < 6; f++) m_top[f] = m_low[f];
        m_lvl--;
      end
    end else begin
      tag = "R4";
    end
    if (en && rt) tag = {tag, "/R7"};
    @(posedge clk);
    #1;
    compare_state(tag);
    @(negedge clk);
    enter_req = 1'b0;
    ret_req   = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0;
    cfg_three_lvl = 1'b1;
    enter_req = 1'b0;
    ret_req = 1'b0;
    randomize_data();
    model_reset();
    @(negedge clk);
    enter_req = 1'b1;        // requests during reset have no effect
    repeat (3) @(negedge clk);
    #1 compare_state("R1");
    enter_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1 compare_state("R1");
    @(negedge clk);

    // R7: return at level 0
    apply(1'b0, 1'b1);
    // R2 twice, R3 deep, R4 ignored at 3
    apply(1'b1, 1'b0);
    apply(1'b1, 1'b0);
    apply(1'b1, 1'b0);
    apply(1'b1, 1'b0);
    // R7: both at once at level 3 -> entry wins, ignored at cap
    apply(1'b1, 1'b1);
    // R6, then R5 twice, then R7 at 0
    apply(1'b0, 1'b1);
    apply(1'b0, 1'b1);
    apply(1'b0, 1'b1);
    apply(1'b0, 1'b1);
    // R4: 2-level mode caps at 2
    cfg_three_lvl = 1'b0;
    apply(1'b1, 1'b0);
    apply(1'b1, 1'b0);
    apply(1'b1, 1'b0);
    apply(1'b1, 1'b1);
    apply(1'b0, 1'b1);
    // R9/R10 corners: upper index bits, largest spacing
    cfg_ext_vec = 1'b0;
    enter_idx = 7'h7F; vec_shift = 5'd31; vec_base = 32'hFFFF_FFF0;
    #1 cmp("R9", "vec_addr corner", vec_addr, want_vec(1'b0, vec_base, enter_idx, vec_shift));
    cfg_ext_vec = 1'b1; enter_idx = 7'd72; vec_shift = 5'd4; vec_base = 32'h0001_0000;
    #1 cmp("R10", "vec_addr corner", vec_addr, 32'h0001_0480);
    cur_psw = 32'hFFFF_FFFF;
    #1 cmp("R8", "new_psw corner", new_psw, 32'hFFFF_FFE0);
    @(negedge clk);

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      bit en, rt;
      r = $urandom % 100;
      if (r < 3) cfg_three_lvl = ~cfg_three_lvl;
      r = $urandom % 100;
      en = (r < 35);
      rt = (r >= 30 && r < 75);
      apply(en, rt);
    end
    finish_run();
  end

endmodule